// File: doc/BRIEF.md
# Lane Start-of-Transmission Timing Monitor

This block observes one serial display data lane whose two single-ended low-power lines have already been sampled and decoded into one of four line states: both lines high (LP-11), the LP-01 request state, the LP-00 bridge state, or high-speed activity. It runs on a fast sample clock. Each cycle spent in the LP-01 and LP-00 states is counted. On every transition into high-speed mode it publishes the measured lengths and reports whether the start-of-transmission sequence was well formed. A well-formed entry visits LP-11, then LP-01, then LP-00, and only then goes to high speed.

The combined LP-01 plus LP-00 time is the low plateau. It is compared with a programmable minimum that resets to the number of sample clocks covering 50 ns. An entry whose plateau falls below that minimum, or that skips one of the two low states, is counted as a missed start of transmission. Any visited low state shorter than 50 ns raises a separate short-state warning. Saturating totals of good and failed entries, and a sticky error flag, stay readable until a clear input is pulsed.

The internal sequencer has five states. ST_IDLE waits for the lane to settle. ST_STOP tracks LP-11. ST_REQ times LP-01. ST_BRIDGE times LP-00. ST_HS marks high speed. The transitions are as follows:
- T_ARM: ST_IDLE to ST_STOP on LP-11.
- T_REQUEST: ST_STOP to ST_REQ on LP-01.
- T_SKIP_REQ: ST_STOP to ST_BRIDGE on LP-00.
- T_BRIDGE: ST_REQ to ST_BRIDGE on LP-00.
- T_ENTER: ST_STOP, ST_REQ or ST_BRIDGE to ST_HS on high speed.
- T_ABORT: ST_REQ or ST_BRIDGE back to ST_STOP on LP-11.
- T_DISORDER: to ST_IDLE when ST_BRIDGE sees LP-01, or when ST_HS sees LP-01 or LP-00.
- T_END: ST_HS to ST_STOP on LP-11.

Top module: `lsm_sot_monitor`

## Requirements
- R1: The `line_state` input is encoded as follows: 2'b11 is LP-11, 2'b01 is LP-01, 2'b00 is LP-00 and 2'b10 is high-speed active. After reset, every measurement output, flag and total is zero, and the plateau minimum equals ceil(50000 / SAMPLE_PS) sample clocks, which is 3 with the default parameters.
- R2: On a T_ENTER transition, `meas_valid` is high for exactly one cycle. It rises after the first clock edge at which high speed is sampled. At that time `req_len` equals the number of edges at which LP-01 was sampled, `exit_to_hs_len` equals the number of edges at which LP-00 was sampled, and `plateau_len` equals their sum. The lengths hold until the next entry.
- R3: When an entry visits both low states, `sot_fail` pulses with `meas_valid` if `plateau_len` is less than the current minimum. Otherwise the entry is counted as good.
- R4: An entry that skips LP-01, skips LP-00, or goes from LP-11 straight to high speed reports `plateau_len` = 0 and raises `sot_fail`. A skipped state reports a length of 0.
- R5: `short_warn` pulses with `meas_valid` when a visited LP-01 or LP-00 state lasted fewer sample clocks than the 50 ns count.
- R6: A cycle with `thr_wr` high loads `thr_data` as the new plateau minimum. The new value applies to every entry that completes after that edge.
- R7: The duration measurements saturate at all ones and do not wrap. This applies to the plateau sum as well.
- R8: `good_cnt` and `fail_cnt` each add one for every good or failed entry, saturate at all ones, and return to zero on `clear`. An entry completing on the same edge as `clear` is counted after the clear.
- R9: `sticky_err` sets on any failed entry and stays set through later good entries until `clear`.
- R10: A return to LP-11 from LP-01 or LP-00 with no high-speed phase produces no `meas_valid` and changes no total. The next entry is timed from scratch.
- R11: High speed that is not preceded by LP-11 is not counted. This covers high speed after reset before any LP-11, and high speed following an out-of-order LP-00 to LP-01 step. Measurement resumes at the next LP-11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sample clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_state | input | 2 | Decoded lane state (see R1) |
| thr_wr | input | 1 | Load strobe for the plateau minimum |
| thr_data | input | DUR_W | New plateau minimum in sample clocks |
| clear | input | 1 | Zeroes totals and sticky flag |
| meas_valid | output | 1 | One-cycle pulse per counted entry |
| req_len | output | DUR_W | LP-01 duration of the last entry |
| exit_to_hs_len | output | DUR_W | Time from leaving LP-01 to high speed (LP-00 duration) |
| plateau_len | output | DUR_W | Combined low plateau of the last entry |
| sot_fail | output | 1 | Missed start-of-transmission pulse |
| short_warn | output | 1 | Short low-state warning pulse |
| good_cnt | output | CNT_W | Total of good entries |
| fail_cnt | output | CNT_W | Total of failed entries |
| sticky_err | output | 1 | Latched failure indication |

## Verification
Every result of an entry appears one clock after the first edge that samples high speed. The result pulses drop one clock after that, and threshold loads and clears take effect at the edge that samples them. The bench changes `line_state` and the strobes on the falling edge and holds each lane state for a counted number of falling edges, so that number of rising edges sample it. It reads the outputs at the falling edge just after the high-speed edge, and again one falling edge later to confirm the pulses have ended. Expected lengths, flags and totals come from a small model in the bench built from the hold counts and the current minimum.

// File: rtl/lsm_pkg.sv
package lsm_pkg;

    // Decoded lane line state
    typedef enum logic [1:0] {
        LINE_LP00 = 2'b00,
        LINE_LP01 = 2'b01,
        LINE_HS   = 2'b10,
        LINE_LP11 = 2'b11
    } line_e;

    // Sequencer states
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_STOP,
        ST_REQ,
        ST_BRIDGE,
        ST_HS
    } mon_state_e;

    // Shortest legal low state and plateau, in picoseconds
    localparam int MIN_LOW_PS = 50000;

    // Index of each timed low state in the duration counter bank
    localparam int IDX_REQ    = 0;
    localparam int IDX_BRIDGE = 1;
    localparam int N_TIMED    = 2;

endpackage

// File: rtl/lsm_dur_ctr.sv
module lsm_dur_ctr #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         start,
    input  logic         hold,
    output logic [W-1:0] q
);

    localparam logic [W-1:0] Q_MAX = '1;
    localparam logic [W-1:0] Q_ONE = W'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (clr) begin
            q <= '0;
        end else if (start) begin
            q <= Q_ONE;
        end else if (hold && (q != Q_MAX)) begin
            q <= q + Q_ONE;
        end
    end

endmodule

// File: rtl/lsm_evt_ctr.sv
module lsm_evt_ctr #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         inc,
    output logic [W-1:0] q
);

    localparam logic [W-1:0] Q_MAX = '1;
    localparam logic [W-1:0] Q_ONE = W'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (clear) begin
            q <= inc ? Q_ONE : '0;
        end else if (inc && (q != Q_MAX)) begin
            q <= q + Q_ONE;
        end
    end

endmodule

// File: rtl/lsm_fsm.sv
module lsm_fsm
    import lsm_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  line_e              line,
    output mon_state_e         state_q,
    output logic               enter,
    output logic               skipped,
    output logic               clr_dur,
    output logic [N_TIMED-1:0] start_v,
    output logic [N_TIMED-1:0] hold_v
);

    mon_state_e nxt;
    logic       skip_req_q;

    // Next-state selection
    always_comb begin
        nxt = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (line == LINE_LP11) nxt = ST_STOP;            // T_ARM
            end
            ST_STOP: begin
                unique case (line)
                    LINE_LP01: nxt = ST_REQ;                      // T_REQUEST
                    LINE_LP00: nxt = ST_BRIDGE;                   // T_SKIP_REQ
                    LINE_HS:   nxt = ST_HS;                       // T_ENTER
                    default:   nxt = ST_STOP;
                endcase
            end
            ST_REQ: begin
                unique case (line)
                    LINE_LP00: nxt = ST_BRIDGE;                   // T_BRIDGE
                    LINE_LP11: nxt = ST_STOP;                     // T_ABORT
                    LINE_HS:   nxt = ST_HS;                       // T_ENTER
                    default:   nxt = ST_REQ;
                endcase
            end
            ST_BRIDGE: begin
                unique case (line)
                    LINE_HS:   nxt = ST_HS;                       // T_ENTER
                    LINE_LP11: nxt = ST_STOP;                     // T_ABORT
                    LINE_LP01: nxt = ST_IDLE;                     // T_DISORDER
                    default:   nxt = ST_BRIDGE;
                endcase
            end
            ST_HS: begin
                unique case (line)
                    LINE_LP11: nxt = ST_STOP;                     // T_END
                    LINE_HS:   nxt = ST_HS;
                    default:   nxt = ST_IDLE;                     // T_DISORDER
                endcase
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // State register, plus the record of a skipped request state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            skip_req_q <= 1'b0;
        end else begin
            state_q <= nxt;
            if (state_q == ST_STOP && nxt == ST_BRIDGE) begin
                skip_req_q <= 1'b1;
            end else if (nxt == ST_STOP) begin
                skip_req_q <= 1'b0;
            end
        end
    end

    // Decoded controls for the datapath
    always_comb begin
        enter   = (nxt == ST_HS) &&
                  (state_q == ST_STOP || state_q == ST_REQ || state_q == ST_BRIDGE);
        skipped = enter && (state_q != ST_BRIDGE || skip_req_q);
        clr_dur = (nxt == ST_STOP) && (state_q != ST_STOP);
        start_v = '0;
        hold_v  = '0;
        start_v[IDX_REQ]    = (state_q == ST_STOP) && (nxt == ST_REQ);
        hold_v[IDX_REQ]     = (state_q == ST_REQ)  && (nxt == ST_REQ);
        start_v[IDX_BRIDGE] = (state_q == ST_STOP || state_q == ST_REQ) &&
                              (nxt == ST_BRIDGE);
        hold_v[IDX_BRIDGE]  = (state_q == ST_BRIDGE) && (nxt == ST_BRIDGE);
    end

endmodule

// File: rtl/lsm_sot_monitor.sv
module lsm_sot_monitor
    import lsm_pkg::*;
#(
    parameter int SAMPLE_PS = 20000,
    parameter int DUR_W     = 8,
    parameter int CNT_W     = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       line_state,
    input  logic             thr_wr,
    input  logic [DUR_W-1:0] thr_data,
    input  logic             clear,
    output logic             meas_valid,
    output logic [DUR_W-1:0] req_len,
    output logic [DUR_W-1:0] exit_to_hs_len,
    output logic [DUR_W-1:0] plateau_len,
    output logic             sot_fail,
    output logic             short_warn,
    output logic [CNT_W-1:0] good_cnt,
    output logic [CNT_W-1:0] fail_cnt,
    output logic             sticky_err
);

    localparam int               MIN_CLKS  = (MIN_LOW_PS + SAMPLE_PS - 1) / SAMPLE_PS;
    localparam logic [DUR_W-1:0] DEF_THR   = DUR_W'(MIN_CLKS);
    localparam logic [DUR_W-1:0] SHORT_MIN = DUR_W'(MIN_CLKS);

    line_e              line;
    mon_state_e         state_q;
    logic               enter;
    logic               skipped;
    logic               clr_dur;
    logic [N_TIMED-1:0] start_v;
    logic [N_TIMED-1:0] hold_v;
    logic [DUR_W-1:0]   dur_q [N_TIMED];
    logic [DUR_W-1:0]   thr_q;
    logic [DUR_W:0]     sum_w;
    logic [DUR_W-1:0]   sum_sat;
    logic               ent_fail;
    logic               ent_warn;
    logic [1:0]         tally_inc;
    logic [CNT_W-1:0]   tally_q [2];

    assign line = line_e'(line_state);

    lsm_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .line    (line),
        .state_q (state_q),
        .enter   (enter),
        .skipped (skipped),
        .clr_dur (clr_dur),
        .start_v (start_v),
        .hold_v  (hold_v)
    );

    // One duration counter per timed low state
    for (genvar g = 0; g < N_TIMED; g++) begin : g_dur
        lsm_dur_ctr #(.W(DUR_W)) u_dur (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (clr_dur),
            .start (start_v[g]),
            .hold  (hold_v[g]),
            .q     (dur_q[g])
        );
    end

    // Programmable plateau minimum
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            thr_q <= DEF_THR;
        end else if (thr_wr) begin
            thr_q <= thr_data;
        end
    end

    // Entry evaluation
    always_comb begin
        sum_w    = {1'b0, dur_q[IDX_REQ]} + {1'b0, dur_q[IDX_BRIDGE]};
        sum_sat  = sum_w[DUR_W] ? '1 : sum_w[DUR_W-1:0];
        ent_fail = skipped || (sum_sat < thr_q);
        ent_warn = 1'b0;
        for (int i = 0; i < N_TIMED; i++) begin
            if (dur_q[i] != '0 && dur_q[i] < SHORT_MIN) ent_warn = 1'b1;
        end
    end

    // Published results
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meas_valid     <= 1'b0;
            req_len        <= '0;
            exit_to_hs_len <= '0;
            plateau_len    <= '0;
            sot_fail       <= 1'b0;
            short_warn     <= 1'b0;
            sticky_err     <= 1'b0;
        end else begin
            meas_valid <= enter;
            sot_fail   <= enter && ent_fail;
            short_warn <= enter && ent_warn;
            if (enter) begin
                req_len        <= dur_q[IDX_REQ];
                exit_to_hs_len <= dur_q[IDX_BRIDGE];
                plateau_len    <= skipped ? '0 : sum_sat;
            end
            if (clear) begin
                sticky_err <= enter && ent_fail;
            end else if (enter && ent_fail) begin
                sticky_err <= 1'b1;
            end
        end
    end

    // Good and failed entry totals
    assign tally_inc[0] = enter && !ent_fail;
    assign tally_inc[1] = enter && ent_fail;

    for (genvar t = 0; t < 2; t++) begin : g_tally
        lsm_evt_ctr #(.W(CNT_W)) u_tally (
            .clk   (clk),
            .rst_n (rst_n),
            .clear (clear),
            .inc   (tally_inc[t]),
            .q     (tally_q[t])
        );
    end

    assign good_cnt = tally_q[0];
    assign fail_cnt = tally_q[1];

endmodule

// File: rtl/lsm_sot_monitor_chk.sv
module lsm_sot_monitor_chk #(
    parameter int DUR_W = 8,
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       line_state,
    input logic             clear,
    input logic [DUR_W-1:0] thr_q,
    input logic             meas_valid,
    input logic [DUR_W-1:0] plateau_len,
    input logic             sot_fail,
    input logic [CNT_W-1:0] good_cnt,
    input logic [CNT_W-1:0] fail_cnt,
    input logic             sticky_err
);

    // R2: a result is a single-cycle pulse
    p_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        meas_valid |=> !meas_valid);

    // R2: a result follows a high-speed sample
    p_after_hs_r2: assert property (@(posedge clk) disable iff (!rst_n)
        meas_valid |-> $past(line_state) == 2'b10);

    // R3: a short plateau is always a failure
    p_short_plateau_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (meas_valid && plateau_len < thr_q) |-> sot_fail);

    // R4: a zero plateau is always a failure
    p_zero_plateau_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (meas_valid && plateau_len == '0) |-> sot_fail);

    // R9: the latch follows a failure and holds without clear
    p_fail_sets_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (meas_valid && sot_fail) |-> sticky_err);

    p_sticky_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (sticky_err && !clear) |=> sticky_err);

    // R8: totals move only with a result or a clear
    p_counts_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !clear |=> (meas_valid || ($stable(good_cnt) && $stable(fail_cnt))));

    // R8: a failed entry adds one to a non-full failure total
    p_fail_incr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((!clear && fail_cnt != '1) ##1 (meas_valid && sot_fail))
            |-> fail_cnt == CNT_W'($past(fail_cnt) + 1'b1));

endmodule

bind lsm_sot_monitor lsm_sot_monitor_chk #(
    .DUR_W (DUR_W),
    .CNT_W (CNT_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .line_state  (line_state),
    .clear       (clear),
    .thr_q       (thr_q),
    .meas_valid  (meas_valid),
    .plateau_len (plateau_len),
    .sot_fail    (sot_fail),
    .good_cnt    (good_cnt),
    .fail_cnt    (fail_cnt),
    .sticky_err  (sticky_err)
);

// File: tb/tb_lsm_sot_monitor.sv
module tb_lsm_sot_monitor;

    localparam int DUR_W = 8;
    localparam int CNT_W = 8;
    localparam int DMAX  = 255;
    localparam int CMAX  = 255;
    localparam int SHORT = 3;

    localparam logic [1:0] L11 = 2'b11;
    localparam logic [1:0] L01 = 2'b01;
    localparam logic [1:0] L00 = 2'b00;
    localparam logic [1:0] LHS = 2'b10;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [1:0]       line_state = LHS;
    logic             thr_wr = 1'b0;
    logic [DUR_W-1:0] thr_data = '0;
    logic             clear = 1'b0;
    logic             meas_valid;
    logic [DUR_W-1:0] req_len;
    logic [DUR_W-1:0] exit_to_hs_len;
    logic [DUR_W-1:0] plateau_len;
    logic             sot_fail;
    logic             short_warn;
    logic [CNT_W-1:0] good_cnt;
    logic [CNT_W-1:0] fail_cnt;
    logic             sticky_err;

    int n_chk  = 0;
    int n_fail = 0;
    int thr_m  = 3;
    int exp_good = 0;
    int exp_fail = 0;
    int exp_sticky = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    lsm_sot_monitor #(
        .SAMPLE_PS (20000),
        .DUR_W     (DUR_W),
        .CNT_W     (CNT_W)
    ) dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .line_state     (line_state),
        .thr_wr         (thr_wr),
        .thr_data       (thr_data),
        .clear          (clear),
        .meas_valid     (meas_valid),
        .req_len        (req_len),
        .exit_to_hs_len (exit_to_hs_len),
        .plateau_len    (plateau_len),
        .sot_fail       (sot_fail),
        .short_warn     (short_warn),
        .good_cnt       (good_cnt),
        .fail_cnt       (fail_cnt),
        .sticky_err     (sticky_err)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int sat(input int v, input int m);
        return (v > m) ? m : v;
    endfunction

    task automatic hold(input logic [1:0] s, input int n);
        line_state = s;
        repeat (n) @(negedge clk);
    endtask

    task automatic chk_totals(input string req);
        chk(req, "good_cnt", int'(good_cnt), exp_good);
        chk(req, "fail_cnt", int'(fail_cnt), exp_fail);
        chk(req, "sticky_err", int'(sticky_err), exp_sticky);
    endtask

    // One entry: LP-11, a cycles of LP-01, b cycles of LP-00, then HS (0 means skipped)
    task automatic do_entry(input int a, input int b, input string req);
        int  pl;
        bit  skip;
        bit  fl;
        bit  wn;
        skip = (a == 0) || (b == 0);
        pl   = skip ? 0 : sat(a + b, DMAX);
        fl   = skip || (pl < thr_m);
        wn   = (a > 0 && a < SHORT) || (b > 0 && b < SHORT);
        hold(L11, 2);
        if (a > 0) hold(L01, a);
        if (b > 0) hold(L00, b);
        hold(LHS, 1);
        if (fl) begin
            exp_fail = sat(exp_fail + 1, CMAX);
            exp_sticky = 1;
        end else begin
            exp_good = sat(exp_good + 1, CMAX);
        end
        chk("R2", "meas_valid rise", int'(meas_valid), 1);
        chk(req, "req_len", int'(req_len), sat(a, DMAX));
        chk(req, "exit_to_hs_len", int'(exit_to_hs_len), sat(b, DMAX));
        chk(req, "plateau_len", int'(plateau_len), pl);
        chk(req, "sot_fail", int'(sot_fail), int'(fl));
        chk("R5", "short_warn", int'(short_warn), int'(wn));
        chk_totals(req);
        hold(LHS, 1);
        chk("R2", "meas_valid drop", int'(meas_valid), 0);
        chk("R2", "sot_fail drop", int'(sot_fail), 0);
        chk("R2", "req_len held", int'(req_len), sat(a, DMAX));
    endtask

    task automatic set_thr(input int v);
        thr_data = DUR_W'(v);
        thr_wr   = 1'b1;
        @(negedge clk);
        thr_wr   = 1'b0;
        thr_m    = v;
    endtask

    task automatic do_clear();
        clear = 1'b1;
        @(negedge clk);
        clear = 1'b0;
        exp_good = 0;
        exp_fail = 0;
        exp_sticky = 0;
        chk_totals("R8");
    endtask

    task automatic t_reset();
        chk("R1", "meas_valid", int'(meas_valid), 0);
        chk("R1", "plateau_len", int'(plateau_len), 0);
        chk("R1", "req_len", int'(req_len), 0);
        chk("R1", "sot_fail", int'(sot_fail), 0);
        chk("R1", "short_warn", int'(short_warn), 0);
        chk_totals("R1");
        // R11: HS right after reset with no LP-11 is not an entry
        hold(LHS, 3);
        chk("R11", "meas_valid after reset", int'(meas_valid), 0);
        chk_totals("R11");
    endtask

    task automatic t_nominal();
        do_entry(4, 6, "R2");
        do_entry(7, 3, "R2");
    endtask

    task automatic t_threshold_default();
        do_entry(1, 1, "R3");   // plateau 2 below reset minimum 3
        do_entry(1, 2, "R3");   // plateau 3 equals minimum: good
        chk("R1", "reset minimum boundary good", int'(sot_fail), 0);
    endtask

    task automatic t_short();
        do_entry(2, 10, "R5");  // LP-01 short only
        do_entry(10, 2, "R5");  // LP-00 short only
        do_entry(3, 3, "R5");   // both at limit: no warning
    endtask

    task automatic t_skip();
        do_entry(0, 6, "R4");   // LP-01 skipped
        do_entry(5, 0, "R4");   // LP-00 skipped
        do_entry(0, 0, "R4");   // LP-11 straight to HS
    endtask

    task automatic t_prog_thr();
        set_thr(20);
        do_entry(10, 9, "R6");
        do_entry(10, 10, "R6");
        set_thr(3);
        do_entry(2, 2, "R6");
    endtask

    task automatic t_saturate();
        do_entry(300, 4, "R7");
        do_entry(200, 100, "R7");
    endtask

    task automatic t_abort();
        hold(L11, 2);
        hold(L01, 4);
        hold(L00, 2);
        hold(L11, 1);
        chk("R10", "meas_valid on abort", int'(meas_valid), 0);
        hold(L01, 3);
        hold(L11, 2);
        chk("R10", "meas_valid on second abort", int'(meas_valid), 0);
        chk_totals("R10");
        do_entry(5, 4, "R10");
    endtask

    task automatic t_disorder();
        hold(L11, 2);
        hold(L01, 2);
        hold(L00, 2);
        hold(L01, 2);
        hold(LHS, 1);
        chk("R11", "meas_valid after disorder", int'(meas_valid), 0);
        hold(LHS, 2);
        chk("R11", "meas_valid in HS", int'(meas_valid), 0);
        chk_totals("R11");
        do_entry(4, 4, "R11");
    endtask

    task automatic t_sticky();
        do_clear();
        do_entry(1, 1, "R9");
        do_entry(5, 5, "R9");
        do_entry(6, 6, "R9");
        chk("R9", "sticky through good entries", int'(sticky_err), 1);
        do_clear();
        chk("R9", "sticky after clear", int'(sticky_err), 0);
    endtask

    task automatic t_counters();
        // Clear and failed entry on the same edge: counted after the clear
        hold(L11, 2);
        hold(L01, 1);
        line_state = LHS;
        clear = 1'b1;
        @(negedge clk);
        clear = 1'b0;
        exp_good = 0;
        exp_fail = 1;
        exp_sticky = 1;
        chk_totals("R8");
        do_clear();
        for (int i = 0; i < 260; i++) begin
            do_entry(4, 4, "R8");
        end
        chk("R8", "good_cnt saturated", int'(good_cnt), CMAX);
        do_clear();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_nominal();
        t_threshold_default();
        t_short();
        t_skip();
        t_prog_thr();
        t_saturate();
        t_abort();
        t_disorder();
        t_sticky();
        t_counters();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog all requirements: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule